// File: doc/BRIEF.md
# Receive FIFO Fill and Timeout Controller

This block sits between an asynchronous serial receiver and the host. Each cycle in which the receiver presents a finished character, the block formats it into a 10-bit entry and appends it to a 32-entry first-in first-out store. The entry holds the character byte and, when enabled, the parity and framing error bits for that character. The host drains the store through a show-ahead read port and can see the current fill level.

The block tells the host when to service the store. It raises a separate sticky flag for each of these events:
- the fill level reaches a programmable threshold;
- a programmable termination byte is stored;
- a programmable number of character times passes after the last received character while data is still waiting;
- a character arrives with a parity or framing error;
- a character is lost because the store is full.

Each flag is cleared by writing a one to its bit of a clear vector. A combined interrupt line is the OR of all five flags.

Top module: `rx_fifo_svc`

## Requirements
- R1: While `rx_en` is low, a presented character is not stored and sets no flag. The level, the read data and all flags are unchanged by it.
- R2: Entry bits [7:0] hold the character byte. When `cfg_wlen7` is 0, the byte is `chr_data[7:0]`. When `cfg_wlen7` is 1, bits [6:0] are `chr_data[6:0]`, and bit 7 is `chr_par` if `cfg_par_keep` is 1, otherwise 0.
- R3: Entry bit 8 is the parity error and bit 9 is the framing error when `cfg_stat_en` is 1. Both bits are 0 when `cfg_stat_en` is 0.
- R4: Entries are read in arrival order. `rd_data` shows the oldest entry, and a cycle with `rd_en` high removes it. `rd_level` gives the number of stored entries. A read of an empty store is ignored. After reset, the level and all flags are zero.
- R5: `irq_thr` (clear bit 0) sets in the cycle the level goes from below `cfg_thr` to at or above it. A `cfg_thr` of 0 disables it.
- R6: `irq_tc` (clear bit 1) sets when `cfg_tc_en` is 1 and a stored entry's bits [7:0] equal `cfg_tc`.
- R7: `irq_to` (clear bit 2) sets exactly `cfg_char_clks*cfg_to_chars` clock edges after the edge that took the last character. It sets only if `cfg_to_en` is 1 and the store is non-empty at that moment. Every new character restarts the count, and the count fires only once per character. Both settings must be at least 1.
- R8: `irq_err` (clear bit 3) sets for every character taken while enabled that has `chr_perr` or `chr_ferr` high, whatever the value of `cfg_stat_en`.
- R9: A character presented while enabled and with the store holding 32 entries is dropped, even if a read happens in the same cycle. It sets `ovr_sticky` (clear bit 4).
- R10: A one on a `flag_clr` bit clears its flag at the next edge. A set condition in the same cycle wins over the clear.
- R11: `irq` is high exactly when any of the five flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_wlen7 | input | 1 | 7-bit character mode |
| cfg_par_keep | input | 1 | Keep the parity bit in bit 7 (7-bit mode) |
| cfg_stat_en | input | 1 | Store error status bits with each entry |
| cfg_thr | input | 6 | Fill threshold, 0 disables |
| cfg_tc_en | input | 1 | Termination byte detection enable |
| cfg_tc | input | 8 | Termination byte |
| cfg_to_en | input | 1 | Idle time-out enable |
| cfg_char_clks | input | 16 | Clocks per character time (at least 1) |
| cfg_to_chars | input | 4 | Character times until time-out (at least 1) |
| chr_valid | input | 1 | Character presented this cycle |
| chr_data | input | 8 | Received data bits |
| chr_par | input | 1 | Received parity bit |
| chr_perr | input | 1 | Parity error for this character |
| chr_ferr | input | 1 | Framing error for this character |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 10 | Oldest entry: {ferr, perr, byte} |
| rd_level | output | 6 | Number of stored entries |
| flag_clr | input | 5 | Write-one-to-clear: thr, tc, to, err, ovr |
| irq_thr | output | 1 | Threshold reached |
| irq_tc | output | 1 | Termination byte stored |
| irq_to | output | 1 | Idle time-out |
| irq_err | output | 1 | Character error seen |
| ovr_sticky | output | 1 | Character dropped on a full store |
| irq | output | 1 | OR of all flags |

## Verification
The in-module assertions check these properties on every cycle:
- the level never exceeds the depth;
- a character that arrives on a full store is dropped and always leaves the overrun flag set;
- a disabled receiver cannot move the level;
- a clear with no competing set empties the error flag;
- a time-out never rises on an empty store.

Some behaviour only the bench's scenarios can show. These are the exact entry formatting under every mode mix, arrival order through wrap-around, and the exact edge at which the time-out fires. They also include the time-out's single firing and its restart by a later character, and the threshold crossing under simultaneous reads and writes.

// File: rtl/rx_fifo_svc.sv
`timescale 1ns/1ps
module rx_fifo_svc #(
  parameter int DEPTH = 32,
  parameter int CW = 16,
  parameter int TW = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          cfg_wlen7,
  input  logic          cfg_par_keep,
  input  logic          cfg_stat_en,
  input  logic [LW-1:0] cfg_thr,
  input  logic          cfg_tc_en,
  input  logic [7:0]    cfg_tc,
  input  logic          cfg_to_en,
  input  logic [CW-1:0] cfg_char_clks,
  input  logic [TW-1:0] cfg_to_chars,
  input  logic          chr_valid,
  input  logic [7:0]    chr_data,
  input  logic          chr_par,
  input  logic          chr_perr,
  input  logic          chr_ferr,
  input  logic          rd_en,
  output logic [9:0]    rd_data,
  output logic [LW-1:0] rd_level,
  input  logic [4:0]    flag_clr,
  output logic          irq_thr,
  output logic          irq_tc,
  output logic          irq_to,
  output logic          irq_err,
  output logic          ovr_sticky,
  output logic          irq
);

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt, cnt_nxt;
  logic [4:0]    flags, set;
  logic [CW-1:0] pre;
  logic [TW-1:0] chc;
  logic          armed;

  wire       take  = chr_valid && rx_en;
  wire       full  = cnt == LW'(DEPTH);
  wire       wr    = take && !full;
  wire       rd    = rd_en && cnt != '0;
  wire [7:0] cbyte = cfg_wlen7 ? {cfg_par_keep & chr_par, chr_data[6:0]} : chr_data;
  wire [9:0] entry = {cfg_stat_en & chr_ferr, cfg_stat_en & chr_perr, cbyte};

  assign cnt_nxt = cnt + LW'(wr) - LW'(rd);

  wire tick    = pre == cfg_char_clks - 1'b1;
  wire expire  = armed && !take && tick && chc == cfg_to_chars - 1'b1;
  wire thr_hit = cfg_thr != '0 && cnt < cfg_thr && cnt_nxt >= cfg_thr;

  assign set = {take && full,
                take && (chr_perr || chr_ferr),
                expire && cfg_to_en && cnt != '0,
                wr && cfg_tc_en && cbyte == cfg_tc,
                thr_hit};

  always_ff @(posedge clk) if (wr) mem[wptr] <= entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      chc   <= '0;
      armed <= 1'b0;
    end else if (take) begin
      pre   <= '0;
      chc   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (tick) begin
        pre <= '0;
        if (chc == cfg_to_chars - 1'b1) armed <= 1'b0;
        else chc <= chc + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set | (flags & ~flag_clr);
  end

  assign rd_data    = mem[rptr];
  assign rd_level   = cnt;
  assign irq_thr    = flags[0];
  assign irq_tc     = flags[1];
  assign irq_to     = flags[2];
  assign irq_err    = flags[3];
  assign ovr_sticky = flags[4];
  assign irq        = |flags;

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_level <= LW'(DEPTH));

  // R9
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && rx_en && rd_level == LW'(DEPTH)) |=> (ovr_sticky && rd_level <= $past(rd_level)));

  // R1
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_en) |=> $stable(rd_level));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[3] && !(chr_valid && rx_en && (chr_perr || chr_ferr))) |=> !irq_err);

  // R7
  to_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to) |-> $past(rd_level != '0));

endmodule

// File: tb/rx_fifo_svc_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_svc_tb_top;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, cfg_wlen7 = 0, cfg_par_keep = 0, cfg_stat_en = 0;
  logic [5:0] cfg_thr = 0;
  logic cfg_tc_en = 0;
  logic [7:0] cfg_tc = 0;
  logic cfg_to_en = 0;
  logic [15:0] cfg_char_clks = 16'd5;
  logic [3:0] cfg_to_chars = 4'd3;
  logic chr_valid = 0, chr_par = 0, chr_perr = 0, chr_ferr = 0, rd_en = 0;
  logic [7:0] chr_data = 0;
  logic [4:0] flag_clr = 0;
  logic [9:0] rd_data;
  logic [5:0] rd_level;
  logic irq_thr, irq_tc, irq_to, irq_err, ovr_sticky, irq;

  rx_fifo_svc dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [9:0] q[$];
  bit e_thr = 0, e_tc = 0, e_err = 0, e_ovr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_entry(input logic [7:0] d, input logic p, input logic pe, input logic fe);
    logic [7:0] b;
    b = cfg_wlen7 ? {cfg_par_keep & p, d[6:0]} : d;
    return {cfg_stat_en & fe, cfg_stat_en & pe, b};
  endfunction

  task automatic cyc(input bit v, input logic [7:0] d, input bit p, input bit pe, input bit fe,
                     input bit rd, input logic [4:0] c);
    int n0, n1;
    bit take, full, dord, wr;
    logic [9:0] ent;
    chr_valid = v; chr_data = d; chr_par = p; chr_perr = pe; chr_ferr = fe;
    rd_en = rd; flag_clr = c;
    #1;
    n0 = q.size();
    take = v && rx_en;
    full = n0 == 32;
    wr = take && !full;
    dord = rd && n0 != 0;
    ent = exp_entry(d, p, pe, fe);
    if (dord) begin
      chk(rd_data == q[0], "R4 read order", 32'(rd_data), 32'(q[0]));
      void'(q.pop_front());
    end
    if (wr) q.push_back(ent);
    n1 = q.size();
    e_thr = (cfg_thr != 0 && n0 < int'(cfg_thr) && n1 >= int'(cfg_thr)) | (e_thr & !c[0]);
    e_tc  = (wr && cfg_tc_en && ent[7:0] == cfg_tc) | (e_tc & !c[1]);
    e_err = (take && (pe || fe)) | (e_err & !c[3]);
    e_ovr = (take && full) | (e_ovr & !c[4]);
    @(negedge clk);
    chr_valid = 0; rd_en = 0; flag_clr = 0;
    chk(32'(rd_level) == 32'(n1), "R4 level", 32'(rd_level), 32'(n1));
    chk(irq_thr == e_thr, "R5 threshold flag", 32'(irq_thr), 32'(e_thr));
    chk(irq_tc == e_tc, "R6 termination flag", 32'(irq_tc), 32'(e_tc));
    chk(irq_err == e_err, "R8 error flag", 32'(irq_err), 32'(e_err));
    chk(ovr_sticky == e_ovr, "R9 overrun flag", 32'(ovr_sticky), 32'(e_ovr));
    chk(irq == (e_thr | e_tc | e_err | e_ovr | irq_to), "R11 combined irq", 32'(irq),
        32'(e_thr | e_tc | e_err | e_ovr | irq_to));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4021);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_level == 0 && irq == 0 && irq_to == 0 && ovr_sticky == 0, "R4 reset state",
        32'({rd_level, irq}), 32'd0);
    rx_en = 1;

    // R2 R3 formatting
    cfg_wlen7 = 1; cfg_par_keep = 1; cfg_stat_en = 1;
    cyc(1, 8'h55, 1, 1, 0, 0, 0);
    chk(rd_data == 10'h1D5, "R2 R3 7-bit kept parity with status", 32'(rd_data), 32'h1D5);
    cyc(0, 0, 0, 0, 0, 1, 5'h08);
    cfg_par_keep = 0; cfg_stat_en = 0;
    cyc(1, 8'hFF, 1, 1, 1, 0, 0);
    chk(rd_data == 10'h07F, "R3 status off, R2 parity dropped", 32'(rd_data), 32'h07F);
    cyc(0, 0, 0, 0, 0, 1, 5'h08);
    cfg_wlen7 = 0; cfg_stat_en = 1;
    cyc(1, 8'hA5, 1, 0, 1, 0, 0);
    chk(rd_data == 10'h2A5, "R2 R3 8-bit with framing error", 32'(rd_data), 32'h2A5);
    cyc(0, 0, 0, 0, 0, 1, 5'h08);

    // R1 disabled receiver
    rx_en = 0; cfg_tc_en = 1; cfg_tc = 8'h33; cfg_thr = 1;
    cyc(1, 8'h33, 0, 1, 1, 0, 0);
    chk(rd_level == 0 && irq == 0, "R1 disabled ignores character", 32'({rd_level, irq}), 32'd0);
    rx_en = 1;
    cyc(1, 8'h33, 0, 0, 0, 0, 0);
    chk(irq_tc == 1 && irq_thr == 1, "R6 R5 termination and threshold", 32'({irq_tc, irq_thr}), 32'h3);
    cyc(0, 0, 0, 0, 0, 1, 5'h03);
    cfg_tc_en = 0; cfg_thr = 0;

    // R10 set wins over clear
    cyc(1, 8'h10, 0, 1, 0, 0, 0);
    cyc(1, 8'h11, 0, 0, 1, 0, 5'h08);
    chk(irq_err == 1, "R10 set beats clear", 32'(irq_err), 32'd1);
    cyc(0, 0, 0, 0, 0, 0, 5'h08);
    chk(irq_err == 0, "R10 clear", 32'(irq_err), 32'd0);
    idle(0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);

    // R7 time-out: 5 clocks x 3 characters
    cfg_to_en = 1;
    cyc(1, 8'h01, 0, 0, 0, 0, 0);
    idle(14);
    chk(irq_to == 0, "R7 not before window", 32'(irq_to), 32'd0);
    idle(1);
    chk(irq_to == 1, "R7 fires at window end", 32'(irq_to), 32'd1);
    idle(40);
    cyc(0, 0, 0, 0, 0, 0, 5'h04);
    idle(40);
    chk(irq_to == 0, "R7 fires once", 32'(irq_to), 32'd0);
    cyc(1, 8'h02, 0, 0, 0, 0, 0);
    idle(10);
    cyc(1, 8'h03, 0, 0, 0, 0, 0);
    idle(14);
    chk(irq_to == 0, "R7 restart on new character", 32'(irq_to), 32'd0);
    idle(1);
    chk(irq_to == 1, "R7 fires after restart", 32'(irq_to), 32'd1);
    cyc(0, 0, 0, 0, 0, 0, 5'h04);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(1, 8'h04, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idle(30);
    chk(irq_to == 0, "R7 no fire when empty", 32'(irq_to), 32'd0);
    cfg_to_en = 0;

    // R9 overflow
    for (int i = 0; i < 32; i++) cyc(1, 8'(i), 0, 0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0, 1, 0);
    chk(ovr_sticky == 1 && rd_level == 31, "R9 drop on full with read", 32'({ovr_sticky, rd_level}), 32'h5F);
    cyc(0, 0, 0, 0, 0, 0, 5'h10);
    chk(ovr_sticky == 0, "R10 overrun cleared", 32'(ovr_sticky), 32'd0);
    while (q.size() != 0) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(rd_level == 0, "R4 read of empty ignored", 32'(rd_level), 32'd0);

    // random mix
    for (int b = 0; b < 8; b++) begin
      int wp, rp;
      cfg_wlen7 = 1'($urandom); cfg_par_keep = 1'($urandom); cfg_stat_en = 1'($urandom);
      cfg_thr = 6'($urandom % 33); cfg_tc_en = 1'($urandom); cfg_tc = 8'($urandom);
      wp = 30 + int'($urandom % 60); rp = 20 + int'($urandom % 60);
      for (int k = 0; k < 400; k++) begin
        logic [7:0] d;
        logic [4:0] c;
        rx_en = ($urandom % 100) < 95;
        d = ($urandom % 8 == 0) ? cfg_tc : 8'($urandom);
        for (int j = 0; j < 5; j++) c[j] = ($urandom % 100) < 5;
        cyc(($urandom % 100) < wp, d, 1'($urandom), ($urandom % 10) == 0, ($urandom % 12) == 0,
            ($urandom % 100) < rp, c);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule